// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles fit in one period of the word clock. It compares that count against a fixed set of nine legal ratios and picks the oversampling mode (8x, 4x or 2x) that the ratio allows. It then produces a divided clock enable for a sigma-delta modulator that runs at 128, 64 or 32 times the sample rate. The word clock is derived from the master clock, so the two are related in frequency. Their phase is arbitrary. The word clock is brought into the master-clock domain through a two-flop synchroniser, and periods are counted between its rising edges.

A new ratio takes effect only after two back-to-back periods measure the same legal count. A count that matches no legal ratio raises an error flag and leaves the current setting in place. Several ratios (128, 192, 256, 384, 512) are legal in more than one mode. For those, a preferred-mode input chooses the mode. When the preferred mode does not allow the measured ratio, the highest oversampling mode that does allow it is used.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While `rst_n` is low, and right after it is asserted, `ratio_code`, `osr_mode`, `ratio_locked`, `ratio_err` and `mod_ce` are all 0.
- R2: The measured period is the number of master-clock cycles between two consecutive rising edges of `wclk_in`. It does not depend on the word clock's duty cycle or on its phase against the master clock, provided the high and low phases each last at least 3 master cycles.
- R3: `ratio_locked` rises only after two consecutive measured periods are equal and legal. After reset with a steady word clock, it is still 0 once the second rising edge has been seen, and it is 1 after the third. Once high, it stays high until reset.
- R4: `ratio_code` encodes the accepted ratio as 0 to 8 for 64, 96, 128, 192, 256, 384, 512, 768 and 1024 master cycles per word, in that order.
- R5: `osr_mode` and `mode_pref` encode 0 = 2x, 1 = 4x and 2 = 8x. The ratios legal in each mode are:
  - 2x: 64 to 256 (codes 0 to 4)
  - 4x: 128 to 512 (codes 2 to 6)
  - 8x: 256 to 1024 (codes 4 to 8)

  The preferred mode is used if it allows the ratio. Otherwise, including when `mode_pref` = 3, the highest mode that allows the ratio is used.
- R6: When a measured period matches no legal ratio, `ratio_err` goes to 1. `ratio_code`, `osr_mode`, `ratio_locked` and the `mod_ce` rate stay unchanged.
- R7: `ratio_err` returns to 0 at the next measured period that matches a legal ratio, even before that ratio has been accepted.
- R8: While locked, `mod_ce` is a single-cycle pulse once every ratio / (32 × 2^`osr_mode`) master cycles. The divisor is therefore always 2, 3, 4, 6 or 8. While unlocked, `mod_ce` stays 0.
- R9: After the word-clock period changes to another legal ratio, the old code and mode stay in force until the new period has been measured twice in a row.
- R10: A change on `mode_pref` takes effect at the next measured period that confirms the current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_in | input | 1 | Word clock, asynchronous to the sampling edge |
| mode_pref | input | 2 | Preferred oversampling mode used to break ties |
| ratio_code | output | 4 | Accepted ratio code (0..8) |
| osr_mode | output | 2 | Selected oversampling mode |
| ratio_locked | output | 1 | A ratio has been accepted |
| ratio_err | output | 1 | Last measured period matched no legal ratio |
| mod_ce | output | 1 | Modulator clock enable pulse |

## Verification
The assertions assume that the word clock is an integer number of master cycles long. They also assume that its high and low phases are each long enough for the synchroniser to see them, and that any change of period happens at a period boundary. The stimulus meets these assumptions by building the word clock from master-clock falling edges, with whole-cycle high and low times of at least five cycles. New periods and duty cycles are loaded only at the start of a period. `mode_pref` is changed only well inside a period, far from any measuring edge.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

    localparam int NUM_RATIO = 9;
    localparam int CODE_W    = 4;
    localparam int MODE_W    = 2;
    localparam int DIV_W     = 4;

    typedef enum logic [MODE_W-1:0] {
        OSR_2X = 2'd0,
        OSR_4X = 2'd1,
        OSR_8X = 2'd2
    } osr_e;

    // Legal ratio for a code: even codes are powers of two from 64,
    // odd codes are 1.5 times the even code below them.
    function automatic int unsigned ratio_of(input int unsigned idx);
        int unsigned base;
        base = idx[0] ? 96 : 64;
        return base << (idx >> 1);
    endfunction

    // Mode m accepts codes 2m .. 2m+4.
    function automatic logic code_fits(input logic [CODE_W-1:0] code,
                                       input logic [MODE_W-1:0] m);
        int unsigned c;
        int unsigned mi;
        c  = 32'(code);
        mi = 32'(m);
        return (mi <= 2) && (c >= 2 * mi) && (c <= 2 * mi + 4);
    endfunction

    // Master cycles per modulator tick: ratio / (32 << mode).
    function automatic logic [DIV_W-1:0] div_of(input logic [CODE_W-1:0] code,
                                                input logic [MODE_W-1:0] m);
        int unsigned r;
        r = ratio_of(32'(code)) >> (5 + 32'(m));
        return DIV_W'(r);
    endfunction

endpackage

// File: rtl/mclk_period_meter.sv
module mclk_period_meter
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk_in,
    output logic             period_vld,
    output logic [CNT_W-1:0] period
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [CNT_W-1:0] per;
    } meter_t;

    meter_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], wclk_in};
        st_d.prev = st_q.sync[1];
        rise      = st_q.sync[1] & ~st_q.prev;
        st_d.vld  = 1'b0;
        if (rise) begin
            st_d.vld  = st_q.seen;
            st_d.per  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + CNT_W'(1);
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_vld = st_q.vld;
    assign period     = st_q.per;

endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]  period,
    input  logic [MODE_W-1:0] mode_pref,
    output logic              hit,
    output logic [CODE_W-1:0] code,
    output logic [MODE_W-1:0] mode
);

    logic [NUM_RATIO-1:0] hit_vec;

    generate
        for (genvar i = 0; i < NUM_RATIO; i++) begin : g_ratio
            localparam logic [CNT_W-1:0] RVAL = CNT_W'(ratio_of(i));
            assign hit_vec[i] = (period == RVAL);
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_RATIO; i++) begin
            if (hit_vec[i]) code = CODE_W'(i);
        end
        hit = |hit_vec;

        if (code_fits(code, mode_pref)) mode = mode_pref;
        else if (code >= CODE_W'(4))    mode = OSR_8X;
        else if (code >= CODE_W'(2))    mode = OSR_4X;
        else                            mode = OSR_2X;
    end

endmodule

// File: rtl/ratio_lock.sv
module ratio_lock
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_vld,
    input  logic [CNT_W-1:0]  period,
    input  logic              hit,
    input  logic [CODE_W-1:0] cand_code,
    input  logic [MODE_W-1:0] cand_mode,
    output logic [CODE_W-1:0] ratio_code,
    output logic [MODE_W-1:0] osr_mode,
    output logic              locked,
    output logic              err
);

    typedef struct packed {
        logic [CNT_W-1:0]  last;
        logic              last_ok;
        logic [CODE_W-1:0] code;
        logic [MODE_W-1:0] mode;
        logic              locked;
        logic              err;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_vld) begin
            st_d.err = ~hit;
            if (hit && st_q.last_ok && (period == st_q.last)) begin
                st_d.code   = cand_code;
                st_d.mode   = cand_mode;
                st_d.locked = 1'b1;
            end
            st_d.last    = period;
            st_d.last_ok = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ratio_code = st_q.code;
    assign osr_mode   = st_q.mode;
    assign locked     = st_q.locked;
    assign err        = st_q.err;

endmodule

// File: rtl/mod_ce_div.sv
module mod_ce_div
    import mclk_ratio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic [MODE_W-1:0] osr_mode,
    output logic              mod_ce
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ce;
    } div_t;

    div_t             st_d, st_q;
    logic [DIV_W-1:0] div_last;

    always_comb begin
        div_last = div_of(ratio_code, osr_mode) - DIV_W'(1);
        st_d     = st_q;
        if (!locked) begin
            st_d = '0;
        end else if (st_q.cnt >= div_last) begin
            st_d.cnt = '0;
            st_d.ce  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
            st_d.ce  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_ce = st_q.ce;

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_in,
    input  logic [MODE_W-1:0] mode_pref,
    output logic [CODE_W-1:0] ratio_code,
    output logic [MODE_W-1:0] osr_mode,
    output logic              ratio_locked,
    output logic              ratio_err,
    output logic              mod_ce
);

    logic              period_vld;
    logic [CNT_W-1:0]  period;
    logic              hit;
    logic [CODE_W-1:0] cand_code;
    logic [MODE_W-1:0] cand_mode;

    mclk_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .wclk_in    (wclk_in),
        .period_vld (period_vld),
        .period     (period)
    );

    ratio_classify #(.CNT_W(CNT_W)) u_class (
        .period    (period),
        .mode_pref (mode_pref),
        .hit       (hit),
        .code      (cand_code),
        .mode      (cand_mode)
    );

    ratio_lock #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_vld (period_vld),
        .period     (period),
        .hit        (hit),
        .cand_code  (cand_code),
        .cand_mode  (cand_mode),
        .ratio_code (ratio_code),
        .osr_mode   (osr_mode),
        .locked     (ratio_locked),
        .err        (ratio_err)
    );

    mod_ce_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .locked     (ratio_locked),
        .ratio_code (ratio_code),
        .osr_mode   (osr_mode),
        .mod_ce     (mod_ce)
    );

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk
    import mclk_ratio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] ratio_code,
    input logic [MODE_W-1:0] osr_mode,
    input logic              ratio_locked,
    input logic              ratio_err,
    input logic              mod_ce
);

    a_r8_ce_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ce |-> ratio_locked);

    a_r8_ce_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ce |=> !mod_ce);

    a_r5_mode_allows_code: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_locked |-> code_fits(ratio_code, osr_mode));

    a_r4_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_code < CODE_W'(NUM_RATIO));

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_locked |=> ratio_locked);

    a_r3_lock_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_locked) |-> !ratio_err);

    a_r6_err_keeps_setting: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_err) |-> ($stable(ratio_code) && $stable(osr_mode) && $stable(ratio_locked)));

    a_r1_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_locked |-> (ratio_code == '0 && osr_mode == '0));

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ratio_code   (ratio_code),
    .osr_mode     (osr_mode),
    .ratio_locked (ratio_locked),
    .ratio_err    (ratio_err),
    .mod_ce       (mod_ce)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wclk;
    logic [1:0] pref;
    logic [3:0] ratio_code;
    logic [1:0] osr_mode;
    logic       ratio_locked;
    logic       ratio_err;
    logic       mod_ce;

    always #4 clk = ~clk;

    mclk_ratio_detect uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wclk_in      (wclk),
        .mode_pref    (pref),
        .ratio_code   (ratio_code),
        .osr_mode     (osr_mode),
        .ratio_locked (ratio_locked),
        .ratio_err    (ratio_err),
        .mod_ce       (mod_ce)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int per      = 256;
    int hi       = 128;
    bit gen_on   = 1'b0;
    int pcount   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    // word clock built from master-clock falling edges; settings load per period
    initial begin
        wclk = 1'b0;
        forever begin
            @(negedge clk);
            if (gen_on) begin
                int p;
                int h;
                p = per;
                h = hi;
                pcount++;
                wclk = 1'b1;
                repeat (h) @(negedge clk);
                wclk = 1'b0;
                repeat (p - h - 1) @(negedge clk);
            end
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_val({t, " code"},   int'(ratio_code),   int'(e[7:4]));
                check_val({t, " mode"},   int'(osr_mode),     int'(e[3:2]));
                check_val({t, " locked"}, int'(ratio_locked), int'(e[1]));
                check_val({t, " err"},    int'(ratio_err),    int'(e[0]));
            end
        end
    end

    task automatic expect_state(input int code, input int mode, input int lk,
                                input int er, input string tag);
        exp_q.push_back({4'(code), 2'(mode), 1'(lk), 1'(er)});
        tag_q.push_back(tag);
        -> chk_ev;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_periods(input int k);
        int t;
        t = pcount + k;
        wait (pcount >= t);
        repeat (per / 2) @(negedge clk);
    endtask

    task automatic check_ce(input int exp_div, input string tag);
        int n;
        int g;
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!mod_ce && g < 5000);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mod_ce && n < 5000);
        check_val({tag, " ce spacing"}, n, exp_div);
    endtask

    task automatic apply(input int p, input int h, input int pf, input int code,
                         input int mode, input int dv, input string tag);
        @(negedge clk);
        per  = p;
        hi   = h;
        pref = 2'(pf);
        wait_periods(3);
        expect_state(code, mode, 1, 0, tag);
        check_ce(dv, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int s;
        int pulses;
        rst_n = 1'b0;
        pref  = 2'd2;
        repeat (5) @(negedge clk);
        expect_state(0, 0, 0, 0, "R1 reset");
        check_val("R1 reset ce", int'(mod_ce), 0);
        rst_n = 1'b1;

        per    = 256;
        hi     = 128;
        gen_on = 1'b1;
        wait (pcount >= 2);
        repeat (128) @(negedge clk);
        expect_state(0, 0, 0, 0, "R3 two edges no lock");
        pulses = 0;
        repeat (60) begin
            @(negedge clk);
            if (mod_ce) pulses++;
        end
        check_val("R8 no ce while unlocked", pulses, 0);
        wait (pcount >= 3);
        repeat (128) @(negedge clk);
        expect_state(4, 2, 1, 0, "R3 R4 lock 256 8x");
        check_ce(2, "R8 256 8x");

        @(negedge clk);
        pref = 2'd1;
        wait_periods(2);
        expect_state(4, 1, 1, 0, "R10 pref 4x");
        check_ce(4, "R8 256 4x");

        @(negedge clk);
        pref = 2'd0;
        wait_periods(2);
        expect_state(4, 0, 1, 0, "R10 pref 2x");
        check_ce(8, "R8 256 2x");

        @(negedge clk);
        per = 1024;
        hi  = 512;
        s   = pcount;
        wait (pcount >= s + 2);
        repeat (512) @(negedge clk);
        expect_state(4, 0, 1, 0, "R9 old ratio held");
        wait (pcount >= s + 3);
        repeat (512) @(negedge clk);
        expect_state(8, 2, 1, 0, "R9 R5 1024 fallback 8x");
        check_ce(8, "R8 1024 8x");

        apply(96, 20, 2, 1, 0, 3, "R2 R5 96 only 2x");
        apply(128, 64, 3, 2, 1, 2, "R5 128 no pref");

        @(negedge clk);
        per = 200;
        hi  = 100;
        s   = pcount;
        wait (pcount >= s + 2);
        repeat (100) @(negedge clk);
        expect_state(2, 1, 1, 1, "R6 bad ratio 200");
        check_ce(2, "R6 divider kept");
        @(negedge clk);
        per = 128;
        hi  = 64;
        s   = pcount;
        wait (pcount >= s + 2);
        repeat (64) @(negedge clk);
        expect_state(2, 1, 1, 0, "R7 err cleared");

        apply(768, 300, 1, 7, 2, 6, "R5 768 8x");
        apply(384, 5, 3, 5, 2, 3, "R2 short high 384");
        apply(192, 96, 0, 3, 0, 6, "R4 192 2x");
        apply(512, 256, 1, 6, 1, 8, "R4 512 4x");

        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_state(0, 0, 0, 0, "R1 reset mid run");
        check_val("R1 reset mid run ce", int'(mod_ce), 0);
        gen_on = 1'b0;
        rst_n  = 1'b1;
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule